// File: doc/BRIEF.md
# Base-4 Full Adder with Carry-In Shift

This block adds two base-4 digits and a carry-in digit. It uses two base-4 lookup tables, one that gives the sum digit and one that gives the carry digit. Each table holds 16 two-bit entries, one for each pair of operand digits. The tables are loaded with the results for a carry-in of zero. A carry-in of one does not need extra tables. Instead, a shift stage raises one table index by one level: the B index for the sum table and the A index for the carry table.

Raising B from 3 wraps it to 0, which gives the correct sum modulo 4. Raising A from 3 cannot be done. In that case a two-way selector replaces the carry-table output with the digit 1, because 3 + B + 1 is always at least 4. The select signal for that path is the NOR of two active-low terms: the decoded carry-in and the top threshold of digit A.

All digits enter and leave in thermometer form. Both tables stay fully programmable, so the block can also act as a general two-input base-4 lookup stage that has the same shift rule. The results are registered once.

Top module: `qfa_top`

## Requirements
- R1: While rst_ni is low, sum_o, cout_o and cin_err_o are all zero, regardless of the other inputs.
- R2: A digit v is carried as three bits, where bit k is 1 exactly when v > k (0=000, 1=001, 2=011, 3=111). The operand digits are decoded by their highest set bit.
- R3: Every output reflects the inputs present at the previous rising clock edge, so the latency is exactly one cycle.
- R4: With carry-in 0, sum_o is the sum-table entry at index 4*A+B, and cout_o is the carry-table entry at the same index. Entry i of a table sits at bits 2i+1:2i of its configuration port.
- R5: With carry-in 1, the sum table is indexed with B+1 modulo 4, so B=3 reads column 0.
- R6: With carry-in 1 and A below 3, the carry table is indexed with A+1 and unchanged B.
- R7: With carry-in 1 and A equal to 3, cout_o is the digit 1 whatever the carry table holds.
- R8: The carry-in flag is bit 0 of cin_i. When bit 1 of cin_i is set (carry-in digit 2 or 3), cin_err_o is 1. The flag is still taken from bit 0.
- R9: When the tables hold entry(A,B) = (A+B) mod 4 for sum and (A+B) div 4 for carry, sum_o equals (A+B+C) mod 4 and cout_o equals (A+B+C) div 4 for all 32 operand combinations.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| a_i | input | 3 | Operand digit A, thermometer |
| b_i | input | 3 | Operand digit B, thermometer |
| cin_i | input | 3 | Carry-in digit, thermometer, legal values 0 or 1 |
| sum_cfg_i | input | 32 | Sum table, 16 two-bit entries |
| cout_cfg_i | input | 32 | Carry table, 16 two-bit entries |
| sum_o | output | 3 | Sum digit, thermometer |
| cout_o | output | 3 | Carry digit, thermometer |
| cin_err_o | output | 1 | Carry-in digit was 2 or 3 |

## Verification
The wrap of the sum index and the carry override fire in the same cycle when A and B are both 3 and the carry-in is 1. Operands with A=3 and B=3 are applied both under the adder tables and under arbitrary tables whose carry entries are not 1. This shows that the sum comes from column 0 while the carry ignores its table. An illegal carry-in digit is also combined with A=3 in one cycle. The error flag and the shifted results must then appear together one cycle later.

// File: rtl/qfa_pkg.sv
package qfa_pkg;
  localparam int LEVELS  = 4;
  localparam int DIG_W   = $clog2(LEVELS);
  localparam int THERM_W = LEVELS - 1;
  localparam int ENTRIES = LEVELS * LEVELS;
  localparam int CFG_W   = ENTRIES * DIG_W;

  typedef logic [DIG_W-1:0]   digit_t;
  typedef logic [THERM_W-1:0] therm_t;

  function automatic therm_t to_therm(digit_t d);
    therm_t t;
    for (int k = 0; k < THERM_W; k++) t[k] = (int'(d) > k);
    return t;
  endfunction
endpackage

// File: rtl/qfa_level_dec.sv
module qfa_level_dec
  import qfa_pkg::*;
(
  input  therm_t t_i,
  output digit_t d_o,
  output logic   top_no
);
  always_comb begin
    d_o = '0;
    for (int k = 0; k < THERM_W; k++)
      if (t_i[k]) d_o = digit_t'(k + 1);
  end

  // active-low top threshold, feeds the overflow NOR
  assign top_no = ~t_i[THERM_W-1];
endmodule

// File: rtl/qfa_shift.sv
module qfa_shift
  import qfa_pkg::*;
(
  input  digit_t d_i,
  input  logic   up_i,
  output digit_t d_o
);
  // one level up; top level wraps to zero
  assign d_o = up_i ? digit_t'(d_i + 1'b1) : d_i;
endmodule

// File: rtl/qfa_lut.sv
module qfa_lut
  import qfa_pkg::*;
(
  input  logic [CFG_W-1:0] cfg_i,
  input  digit_t           row_i,
  input  digit_t           col_i,
  output digit_t           d_o
);
  logic [ENTRIES-1:0] sel;
  digit_t             gated [ENTRIES];

  for (genvar e = 0; e < ENTRIES; e++) begin : g_entry
    assign sel[e]   = ({row_i, col_i} == (DIG_W*2)'(e));
    assign gated[e] = sel[e] ? cfg_i[e*DIG_W +: DIG_W] : '0;
  end

  always_comb begin
    d_o = '0;
    for (int e = 0; e < ENTRIES; e++) d_o = d_o | gated[e];
  end
endmodule

// File: rtl/qfa_top.sv
module qfa_top
  import qfa_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  therm_t           a_i,
  input  therm_t           b_i,
  input  therm_t           cin_i,
  input  logic [CFG_W-1:0] sum_cfg_i,
  input  logic [CFG_W-1:0] cout_cfg_i,
  output therm_t           sum_o,
  output therm_t           cout_o,
  output logic             cin_err_o
);
  localparam digit_t ONE = digit_t'(1);

  digit_t a_d, b_d, c_unused, a_up, b_up, sum_d, cry_d, cout_d;
  logic   a_top_n, b_top_n, c_top_n, cin_n, ovf_sel;

  qfa_level_dec u_dec_a (.t_i(a_i), .d_o(a_d), .top_no(a_top_n));
  qfa_level_dec u_dec_b (.t_i(b_i), .d_o(b_d), .top_no(b_top_n));
  qfa_level_dec u_dec_c (.t_i(cin_i), .d_o(c_unused), .top_no(c_top_n));

  // single extra threshold plus inverter for carry-in
  assign cin_n = ~cin_i[0];

  qfa_shift u_sh_b (.d_i(b_d), .up_i(~cin_n), .d_o(b_up));
  qfa_shift u_sh_a (.d_i(a_d), .up_i(~cin_n), .d_o(a_up));

  qfa_lut u_lut_sum (.cfg_i(sum_cfg_i),  .row_i(a_d),  .col_i(b_up), .d_o(sum_d));
  qfa_lut u_lut_cry (.cfg_i(cout_cfg_i), .row_i(a_up), .col_i(b_d),  .d_o(cry_d));

  assign ovf_sel = ~(cin_n | a_top_n);
  assign cout_d  = ovf_sel ? ONE : cry_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sum_o     <= '0;
      cout_o    <= '0;
      cin_err_o <= 1'b0;
    end else begin
      sum_o     <= to_therm(sum_d);
      cout_o    <= to_therm(cout_d);
      cin_err_o <= cin_i[1];
    end
  end

  logic chk_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chk_q <= 1'b0;
    else         chk_q <= 1'b1;
  end

  AST_CARRY_FORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (chk_q && $past(a_i[THERM_W-1] && cin_i[0])) |-> (cout_o == therm_t'(1))); // R7
  AST_CIN_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_q |-> (cin_err_o == $past(cin_i[1]))); // R8
  AST_SUM_THERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({1'b0, sum_o} + (THERM_W+1)'(1))); // R2
  AST_COUT_THERM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot({1'b0, cout_o} + (THERM_W+1)'(1))); // R2
  AST_RESET_ZERO: assert property (@(posedge clk_i)
    !rst_ni |-> (sum_o == '0 && cout_o == '0 && !cin_err_o)); // R1
endmodule

// File: tb/sim_qfa_top.sv
`timescale 1ns/1ps
module sim_qfa_top;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [2:0]  a_i = '0, b_i = '0, cin_i = '0;
  logic [31:0] sum_cfg_i = '0, cout_cfg_i = '0;
  logic [2:0]  sum_o, cout_o;
  logic        cin_err_o;

  int vecs = 0, errs = 0;
  bit done = 0;
  int s_tab [16];
  int c_tab [16];

  always #2.5 clk_i = ~clk_i;

  qfa_top u0 (.*);

  function automatic logic [2:0] th(int v);
    logic [2:0] t;
    for (int k = 0; k < 3; k++) t[k] = (v > k);
    return t;
  endfunction

  task automatic load_tabs();
    for (int i = 0; i < 16; i++) begin
      sum_cfg_i[2*i +: 2]  = 2'(s_tab[i]);
      cout_cfg_i[2*i +: 2] = 2'(c_tab[i]);
    end
  endtask

  task automatic chk(string rq, logic [2:0] gs, logic [2:0] gc, logic ge,
                     logic [2:0] es, logic [2:0] ec, logic ee);
    vecs++;
    if (gs !== es || gc !== ec || ge !== ee) begin
      errs++;
      $display("FAIL %s: got sum=%b cout=%b err=%b expected sum=%b cout=%b err=%b",
               rq, gs, gc, ge, es, ec, ee);
    end
  endtask

  // apply digits at negedge, check after the capturing edge
  task automatic apply(string rq, int a, int b, int cdig);
    int c, es, ec;
    @(negedge clk_i);
    a_i = th(a); b_i = th(b); cin_i = th(cdig);
    c = (cdig >= 1) ? 1 : 0;
    es = s_tab[a*4 + (c ? (b+1)%4 : b)];
    if (c && a == 3) ec = 1;
    else ec = c_tab[(c ? a+1 : a)*4 + b];
    @(posedge clk_i); #1;
    chk(rq, sum_o, cout_o, cin_err_o, th(es), th(ec), cdig >= 2);
  endtask

  initial begin
    #100000;
    errs++;
    $display("FAIL watchdog: got running expected finished");
    if (!done) $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    // R1 reset with busy inputs
    a_i = 3'b111; b_i = 3'b111; cin_i = 3'b111; sum_cfg_i = '1; cout_cfg_i = '1;
    repeat (3) @(posedge clk_i);
    #1 chk("R1", sum_o, cout_o, cin_err_o, 3'b000, 3'b000, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    // R9 adder tables, exhaustive (covers R5/R6/R7 as well)
    for (int i = 0; i < 16; i++) begin
      s_tab[i] = (i/4 + i%4) % 4;
      c_tab[i] = (i/4 + i%4) / 4;
    end
    load_tabs();
    for (int c = 0; c < 2; c++)
      for (int a = 0; a < 4; a++)
        for (int b = 0; b < 4; b++) begin
          apply("R9", a, b, c);
          vecs++;
          if (sum_o !== th((a+b+c)%4) || cout_o !== th((a+b+c)/4)) begin
            errs++;
            $display("FAIL R9: got sum=%b cout=%b expected sum=%b cout=%b",
                     sum_o, cout_o, th((a+b+c)%4), th((a+b+c)/4));
          end
        end

    // R4/R5/R6/R7 arbitrary tables; carry entries avoid 1 so override is visible
    for (int i = 0; i < 16; i++) begin
      s_tab[i] = (i*7 + 3) % 4;
      c_tab[i] = ((i*5) % 3 == 0) ? 3 : ((i % 2) ? 2 : 0);
    end
    load_tabs();
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) apply("R4", a, b, 0);
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) apply((a == 3) ? "R7" : (b == 3 ? "R5" : "R6"), a, b, 1);

    // R8 illegal carry-in digits, flag from bit 0
    apply("R8", 3, 3, 2);
    apply("R8", 1, 2, 3);
    apply("R8", 0, 3, 2);
    apply("R8", 2, 0, 0);

    // R3 one-cycle latency: change inputs, output must follow after one edge only
    apply("R3", 1, 1, 0);
    @(negedge clk_i);
    a_i = th(2); b_i = th(3); cin_i = th(1);
    #1 chk("R3", sum_o, cout_o, cin_err_o, th(s_tab[5]), th(c_tab[5]), 1'b0);

    // R2 decode by highest set bit: non-monotonic 101 reads as 3
    @(negedge clk_i);
    a_i = 3'b101; b_i = 3'b010; cin_i = th(0);
    @(posedge clk_i); #1;
    chk("R2", sum_o, cout_o, cin_err_o, th(s_tab[3*4+2]), th(c_tab[3*4+2]), 1'b0);

    // R1 asynchronous reset mid-run
    apply("R1", 2, 2, 1);
    #1 rst_ni = 1'b0;
    #0.5 chk("R1", sum_o, cout_o, cin_err_o, 3'b000, 3'b000, 1'b0);
    @(negedge clk_i) rst_ni = 1'b1;

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule